// File: doc/BRIEF.md
# Sequential Tag Prefetch Unit

This block sits beside the tag array of a set-associative instruction cache whose line is one 64-bit word. A normal access spends one cycle in tag lookup before its hit/miss answer is registered. After every completed access the unit copies all ways of the tag row for the following line address into a small side buffer. If the next request targets exactly that line, the answer comes from the buffer and the lookup cycle is skipped.

The unit runs only while both the prefetch enable and the cache-mode input are high. Any write to the tag row held in the buffer throws the buffered row away, so an outdated tag is never used. Each response says whether it came through the short path, and a separate flag marks responses that came through the short path and hit. The data array, refill control and victim selection are outside this block. The tag row write port is driven by that outside logic.

Top module: `tag_prefetch_unit`

## Requirements
- R1: After reset, resp_valid is 0, req_ready is 1 and every way of every set is invalid, so the first access misses.
- R2: A request that does not use the buffer is accepted at edge E0. req_ready is 0 in the cycle after E0. The response is registered at E1 with resp_fast 0, and req_ready is 1 again after E1.
- R3: Address fields: bits [2:0] are ignored, bits [6:3] select the set and bits [15:7] form the tag. resp_hit is 1 when some way of the set is valid and holds that tag. On a hit resp_way is the lowest such way. On a miss resp_way is 0.
- R4: Each completed access, on either path, loads the buffer with the row for line address + 1 (modulo the line space). A request for that exact line, accepted at E0, is answered at E0 with resp_fast 1, and req_ready stays 1.
- R5: resp_pf_hit is 1 exactly when a response has resp_fast 1 and resp_hit 1.
- R6: While pf_en or cache_mode is 0, every access takes the R2 path and the buffer is emptied. After the unit is enabled again, one access must complete before the short path can be used.
- R7: A tag write to the buffered set empties the buffer, whether the write comes in the capture cycle or later. A request for the buffered line that arrives in the same cycle as such a write takes the R2 path and sees the written entry.
- R8: A request for any line other than the buffered one takes the R2 path. This includes a request to the same set with a different tag.
- R9: When the buffered line is used, the result equals the result the R2 path would return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_en | input | 1 | Prefetch enable |
| cache_mode | input | 1 | Memory system is in cache mode |
| req_valid | input | 1 | Access request |
| req_addr | input | 16 | Byte address of the access |
| req_ready | output | 1 | Request can be accepted this cycle |
| wr_en | input | 1 | Tag row write strobe |
| wr_set | input | 4 | Set to write |
| wr_way | input | 2 | Way to write |
| wr_tag | input | 9 | Tag value to write |
| wr_vld | input | 1 | Valid bit to write (0 invalidates) |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Tag matched |
| resp_way | output | 2 | Matching way |
| resp_fast | output | 1 | Answer came from the prefetch buffer |
| resp_pf_hit | output | 1 | Prefetch hit pulse |

## Verification
The assertions assume that requests are driven only while req_ready is high and that the control inputs change only between clock edges. The bench issues each request from a task that waits for the previous response before it drives the next one, so no request is ever presented during the lookup cycle. The bench also keeps tag writes away from any set whose lookup is in progress, except in the case that is tested on purpose, where the write lands in the acceptance cycle.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
    localparam int ADDR_W = 16;
    localparam int OFS_W  = 3;
    localparam int SET_W  = 4;
    localparam int WAY_N  = 4;
    localparam int TAG_W  = ADDR_W - OFS_W - SET_W;
    localparam int LINE_W = ADDR_W - OFS_W;
    localparam int SET_N  = 1 << SET_W;
    localparam int WAY_W  = (WAY_N > 1) ? $clog2(WAY_N) : 1;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [SET_W-1:0]  set_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WAY_W-1:0]  way_t;

    typedef struct packed {
        logic vld;
        tag_t tag;
    } ent_t;

    typedef ent_t [WAY_N-1:0] row_t;

    typedef struct packed {
        logic hit;
        way_t way;
    } look_t;

    typedef struct packed {
        logic hit;
        way_t way;
        logic fast;
    } resp_t;

    typedef enum logic {ST_IDLE, ST_LOOK} st_t;

    function automatic set_t line_set(line_t l);
        return l[SET_W-1:0];
    endfunction

    function automatic tag_t line_tag(line_t l);
        return l[LINE_W-1:SET_W];
    endfunction

    // lowest matching way wins
    function automatic look_t row_match(row_t r, tag_t t);
        look_t res;
        res = '0;
        for (int w = WAY_N - 1; w >= 0; w--) begin
            if (r[w].vld && (r[w].tag == t)) begin
                res.hit = 1'b1;
                res.way = way_t'(w);
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/tpf_tag_store.sv
module tpf_tag_store
    import tpf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  set_t wr_set,
    input  way_t wr_way,
    input  ent_t wr_ent,
    input  set_t rd_a_set,
    output row_t rd_a_row,
    input  set_t rd_b_set,
    output row_t rd_b_row
);
    row_t rows [SET_N];

    for (genvar s = 0; s < SET_N; s++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                rows[s] <= '0;
            end else if (wr_en && (wr_set == set_t'(s))) begin
                rows[s][wr_way] <= wr_ent;
            end
        end
    end

    assign rd_a_row = rows[rd_a_set];
    assign rd_b_row = rows[rd_b_set];
endmodule

// File: rtl/tpf_pf_buffer.sv
module tpf_pf_buffer
    import tpf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  cap_en,
    input  line_t cap_line,
    input  row_t  cap_row,
    input  logic  wr_en,
    input  set_t  wr_set,
    output logic  buf_vld,
    output line_t buf_line,
    output row_t  buf_row
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_vld  <= 1'b0;
            buf_line <= '0;
            buf_row  <= '0;
        end else if (!active) begin
            buf_vld <= 1'b0;
        end else if (cap_en) begin
            buf_vld  <= !(wr_en && (wr_set == line_set(cap_line)));
            buf_line <= cap_line;
            buf_row  <= cap_row;
        end else if (wr_en && (wr_set == line_set(buf_line))) begin
            buf_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/tag_prefetch_unit.sv
module tag_prefetch_unit
    import tpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pf_en,
    input  logic              cache_mode,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_vld,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WAY_W-1:0]  resp_way,
    output logic              resp_fast,
    output logic              resp_pf_hit
);
    st_t   state;
    line_t look_line;
    resp_t resp_q;
    logic  resp_v_q;

    line_t req_line;
    logic  active;
    logic  buf_vld;
    line_t buf_line;
    row_t  buf_row;
    row_t  look_row;
    row_t  next_row;
    logic  fast_take;
    logic  slow_take;
    logic  cap_en;
    line_t cap_line;
    look_t buf_res;
    look_t look_res;
    ent_t  wr_ent;

    assign req_line  = req_addr[ADDR_W-1:OFS_W];
    assign active    = pf_en && cache_mode;
    assign req_ready = (state == ST_IDLE);
    assign wr_ent    = '{vld: wr_vld, tag: wr_tag};

    assign fast_take = req_valid && req_ready && active && buf_vld
                       && (req_line == buf_line)
                       && !(wr_en && (wr_set == line_set(buf_line)));
    assign slow_take = req_valid && req_ready && !fast_take;

    assign cap_en   = fast_take || (state == ST_LOOK);
    assign cap_line = (fast_take ? req_line : look_line) + line_t'(1);

    assign buf_res  = row_match(buf_row, line_tag(req_line));
    assign look_res = row_match(look_row, line_tag(look_line));

    tpf_tag_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_set   (wr_set),
        .wr_way   (wr_way),
        .wr_ent   (wr_ent),
        .rd_a_set (line_set(look_line)),
        .rd_a_row (look_row),
        .rd_b_set (line_set(cap_line)),
        .rd_b_row (next_row)
    );

    tpf_pf_buffer u_buf (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .cap_en   (cap_en),
        .cap_line (cap_line),
        .cap_row  (next_row),
        .wr_en    (wr_en),
        .wr_set   (wr_set),
        .buf_vld  (buf_vld),
        .buf_line (buf_line),
        .buf_row  (buf_row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            look_line <= '0;
            resp_v_q  <= 1'b0;
            resp_q    <= '0;
        end else begin
            resp_v_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (fast_take) begin
                        resp_v_q <= 1'b1;
                        resp_q   <= '{hit: buf_res.hit, way: buf_res.way, fast: 1'b1};
                    end else if (slow_take) begin
                        look_line <= req_line;
                        state     <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    resp_v_q <= 1'b1;
                    resp_q   <= '{hit: look_res.hit, way: look_res.way, fast: 1'b0};
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign resp_valid  = resp_v_q;
    assign resp_hit    = resp_v_q && resp_q.hit;
    assign resp_way    = resp_q.way;
    assign resp_fast   = resp_v_q && resp_q.fast;
    assign resp_pf_hit = resp_v_q && resp_q.fast && resp_q.hit;
endmodule

// File: rtl/tpf_checker.sv
module tpf_checker (
    input logic clk,
    input logic rst,
    input logic pf_en,
    input logic cache_mode,
    input logic req_valid,
    input logic req_ready,
    input logic resp_valid,
    input logic resp_hit,
    input logic resp_fast,
    input logic resp_pf_hit
);
    // R5
    pf_hit_flag_chk: assert property (@(posedge clk) disable iff (rst)
        resp_pf_hit |-> (resp_valid && resp_fast && resp_hit));

    // R6
    gate_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fast) |-> $past(pf_en && cache_mode));

    // R2
    look_len_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> req_ready);

    // R2
    slow_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> (resp_valid && !resp_fast));

    // R4
    fast_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fast) |-> $past(req_valid && req_ready));

    // R2
    resp_src_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ($past(!req_ready) || $past(req_valid && req_ready)));
endmodule

bind tag_prefetch_unit tpf_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .pf_en       (pf_en),
    .cache_mode  (cache_mode),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .resp_fast   (resp_fast),
    .resp_pf_hit (resp_pf_hit)
);

// File: tb/tb_tag_prefetch_unit.sv
module tb_tag_prefetch_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    // {op(1:write), tag(9), set(4), ofs(3), way(2), flag(valid/exp_hit), exp_fast}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b1, 9'd5,   4'd2,  3'd0, 2'd1, 1'b1, 1'b0},
        {1'b1, 9'd5,   4'd3,  3'd0, 2'd0, 1'b1, 1'b0},
        {1'b1, 9'd5,   4'd4,  3'd0, 2'd3, 1'b1, 1'b0},
        {1'b0, 9'd5,   4'd2,  3'd0, 2'd1, 1'b1, 1'b0},
        {1'b0, 9'd5,   4'd3,  3'd4, 2'd0, 1'b1, 1'b1},
        {1'b0, 9'd5,   4'd4,  3'd0, 2'd3, 1'b1, 1'b1},
        {1'b0, 9'd5,   4'd5,  3'd0, 2'd0, 1'b0, 1'b1},
        {1'b0, 9'd7,   4'd6,  3'd0, 2'd0, 1'b0, 1'b0},
        {1'b0, 9'd5,   4'd2,  3'd0, 2'd1, 1'b1, 1'b0},
        {1'b1, 9'd9,   4'd3,  3'd0, 2'd2, 1'b1, 1'b0},
        {1'b0, 9'd5,   4'd3,  3'd0, 2'd0, 1'b1, 1'b0},
        {1'b0, 9'd5,   4'd4,  3'd0, 2'd3, 1'b1, 1'b1},
        {1'b1, 9'd5,   4'd6,  3'd0, 2'd2, 1'b1, 1'b0},
        {1'b1, 9'd5,   4'd6,  3'd0, 2'd1, 1'b1, 1'b0},
        {1'b0, 9'd5,   4'd5,  3'd0, 2'd0, 1'b0, 1'b1},
        {1'b0, 9'd5,   4'd6,  3'd0, 2'd1, 1'b1, 1'b1},
        {1'b1, 9'd511, 4'd15, 3'd0, 2'd0, 1'b1, 1'b0},
        {1'b1, 9'd0,   4'd0,  3'd0, 2'd3, 1'b1, 1'b0},
        {1'b0, 9'd511, 4'd15, 3'd0, 2'd0, 1'b1, 1'b0},
        {1'b0, 9'd0,   4'd0,  3'd0, 2'd3, 1'b1, 1'b1},
        {1'b1, 9'd0,   4'd0,  3'd0, 2'd3, 1'b0, 1'b0},
        {1'b0, 9'd0,   4'd0,  3'd0, 2'd0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pf_en = 1'b1;
    logic        cache_mode = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_set = '0;
    logic [1:0]  wr_way = '0;
    logic [8:0]  wr_tag = '0;
    logic        wr_vld = 1'b0;
    logic        resp_valid;
    logic        resp_hit;
    logic [1:0]  resp_way;
    logic        resp_fast;
    logic        resp_pf_hit;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tag_prefetch_unit dut (
        .clk(clk), .rst(rst), .pf_en(pf_en), .cache_mode(cache_mode),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_tag(wr_tag),
        .wr_vld(wr_vld), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_way(resp_way), .resp_fast(resp_fast), .resp_pf_hit(resp_pf_hit)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [8:0] tag, input logic [3:0] set,
                            input logic [1:0] way, input logic vld);
        wr_en = 1'b1; wr_tag = tag; wr_set = set; wr_way = way; wr_vld = vld;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // request at a negedge, optional tag write in the same cycle
    task automatic do_access(input logic [15:0] addr, input bit exp_hit,
                             input logic [1:0] exp_way, input bit exp_fast,
                             input bit with_wr, input logic [8:0] w_tag,
                             input logic [3:0] w_set, input logic [1:0] w_way);
        int lat;
        string lreq;
        lreq = exp_fast ? "R4" : "R2";
        check(req_ready == 1'b1, lreq, "ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_addr = addr;
        if (with_wr) begin
            wr_en = 1'b1; wr_tag = w_tag; wr_set = w_set; wr_way = w_way; wr_vld = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        check(req_ready == exp_fast, lreq, "ready after accept", int'(req_ready), int'(exp_fast));
        lat = 1;
        while (!resp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        check(lat == (exp_fast ? 1 : 2), lreq, "latency", lat, exp_fast ? 1 : 2);
        check(resp_fast == exp_fast, lreq, "fast flag", int'(resp_fast), int'(exp_fast));
        check(resp_hit == exp_hit, "R3", "hit", int'(resp_hit), int'(exp_hit));
        check(resp_way == (exp_hit ? exp_way : 2'd0), "R3", "way", int'(resp_way),
              exp_hit ? int'(exp_way) : 0);
        check(resp_pf_hit == (exp_fast && exp_hit), "R5", "pf hit", int'(resp_pf_hit),
              int'(exp_fast && exp_hit));
        @(negedge clk);
        check(resp_valid == 1'b0, "R2", "single-cycle strobe", int'(resp_valid), 0);
    endtask

    function automatic logic [15:0] ad(input logic [8:0] t, input logic [3:0] s);
        return {t, s, 3'd0};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(resp_valid == 1'b0, "R1", "resp_valid after reset", int'(resp_valid), 0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
        do_access(ad(9'd5, 4'd2), 1'b0, 2'd0, 1'b0, 1'b0, '0, '0, '0);   // R1 empty store

        // table walk: R3 R4 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][20]) begin
                do_write(VEC[i][19:11], VEC[i][10:7], VEC[i][3:2], VEC[i][1]);
            end else begin
                do_access(VEC[i][19:4], VEC[i][1], VEC[i][3:2], VEC[i][0],
                          1'b0, '0, '0, '0);
            end
        end

        // R6 prefetch disabled
        pf_en = 1'b0;
        do_access(ad(9'd5, 4'd2), 1'b1, 2'd1, 1'b0, 1'b0, '0, '0, '0);
        do_access(ad(9'd5, 4'd3), 1'b1, 2'd0, 1'b0, 1'b0, '0, '0, '0);
        pf_en = 1'b1;
        do_access(ad(9'd5, 4'd3), 1'b1, 2'd0, 1'b0, 1'b0, '0, '0, '0);  // R6 buffer emptied
        do_access(ad(9'd5, 4'd4), 1'b1, 2'd3, 1'b1, 1'b0, '0, '0, '0);  // R4 R9
        // R6 cache mode off
        cache_mode = 1'b0;
        do_access(ad(9'd5, 4'd5), 1'b0, 2'd0, 1'b0, 1'b0, '0, '0, '0);
        cache_mode = 1'b1;
        do_access(ad(9'd5, 4'd6), 1'b1, 2'd1, 1'b0, 1'b0, '0, '0, '0);
        // R7 write to buffered set in the request cycle
        do_access(ad(9'd5, 4'd7), 1'b1, 2'd2, 1'b0, 1'b1, 9'd5, 4'd7, 2'd2);
        do_access(ad(9'd5, 4'd8), 1'b0, 2'd0, 1'b1, 1'b0, '0, '0, '0);  // R4
        // R8 same set as buffered line, other tag
        do_access(ad(9'd6, 4'd9), 1'b0, 2'd0, 1'b0, 1'b0, '0, '0, '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule